// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the addressing layer of a 1-Wire slave device. It sits between a bit-level front end and a memory-command layer. The front end reports each completed timeslot together with the resolved bus level. It also reports each bus reset and whether that reset was of the short, overdrive length. After every reset the layer collects one 8-bit ROM command, least significant bit first. It then either returns the device's 64-bit registration number, compares it against bits written by the master, runs the bitwise search arbitration, or skips addressing altogether.

The registration number is built from parameters: a family code in bits 7:0, a 48-bit serial number in bits 55:8, and a CRC-8 in bits 63:56 that is computed at elaboration. The layer keeps two flags. The resume flag lets a device that was addressed last time be reached again without sending the number. The overdrive flag tells the timing layer to use the fast slot timing. When addressing succeeds, the layer emits a one-cycle select pulse to the memory layer and then stays silent until the next reset. When addressing fails, it also stays silent until the next reset. Bits it sends are presented as an open-drain request: when `txEn` is high, the front end pulls the line low in that slot if `txBit` is 0.

Top module: `owRomSelect`

## Requirements
- R1: After power-up, before the first bus reset, timeslots are ignored: no select pulse, `txEn` low and `odMode` low.
- R2: After each bus reset an 8-bit command is collected LSB first. A reset at any bit position abandons the command in progress and starts a fresh command collection.
- R3: Command 33h (read) drives 64 read slots with the ID LSB first, then pulses select. The ID holds the family code in bits 7:0, the serial in bits 55:8 and, in bits 63:56, the CRC-8 of bits 55:0 with polynomial x^8+x^5+x^4+1 from a zero start. Running the CRC over all 64 bits therefore leaves zero.
- R4: Command 55h (match) takes 64 written bits. If all 64 equal the ID, the layer pulses select and sets the resume flag. A mismatch at any position gives no select, and the layer does not drive until the next reset.
- R5: Command F0h (search) works in three slots per ID bit: the layer sends the ID bit, then sends its complement, then reads the master's bit. If the master's bit differs, the layer goes silent. If all 64 bits agree, it pulses select and sets the resume flag.
- R6: Command CCh (skip) pulses select right after the command byte and clears the resume flag.
- R7: Command A5h (resume) pulses select only when the resume flag is set. Otherwise the layer stays silent until the next reset.
- R8: Command 3Ch (overdrive skip) sets `odMode`, clears the resume flag and pulses select. `odMode` rises only at the end of a command byte.
- R9: Command 69h (overdrive match) sets `odMode` when the command byte completes. A full match pulses select and sets the resume flag. A mismatch clears `odMode`.
- R10: A standard-length reset (`rstShort` low) clears `odMode`. A short reset (`rstShort` high) leaves `odMode` unchanged.
- R11: Any other command code gives no select and no driving until the next reset, and it leaves the resume flag unchanged.
- R12: `memSel` lasts exactly one cycle per successful selection. `txEn` is never high in a slot where the master writes (command, match, and the third slot of each search bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReset | input | 1 | One-cycle pulse: a bus reset/presence cycle finished |
| rstShort | input | 1 | Qualifies busReset: reset had overdrive length |
| slotStb | input | 1 | One-cycle pulse: a timeslot completed |
| slotBit | input | 1 | Resolved bus level sampled in that timeslot |
| txEn | output | 1 | Layer owns the coming slot as a read slot |
| txBit | output | 1 | Bit to send in the coming slot (0 pulls the line low) |
| memSel | output | 1 | One-cycle pulse handing the bus to the memory layer |
| odMode | output | 1 | Overdrive speed flag for the timing layer |

## Verification
The hardest behaviours to reach from the ports are losing arbitration at a particular bit deep inside a match or search, and the resume flag as it looks after a failed attempt. The flag is not visible directly. The bench brings it out by following each attempt with a reset and a resume command, and by counting select pulses. The mismatch position is swept over every one of the 64 match bits. Search is broken at the first, a middle and the last bit. Resets are injected in the middle of a command byte and in the middle of a read sequence.

// File: rtl/owRomPkg.sv
package owRomPkg;

  localparam int ID_BITS  = 64;
  localparam int CMD_BITS = 8;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH
  } romState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic phClr;
    logic phInc;
    logic cmdShift;
  } dpCtl_t;

  // reflected CRC-8, polynomial x^8+x^5+x^4+1, zero start, LSB first
  function automatic logic [7:0] idCrc(input logic [55:0] body);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/romIdPath.sv
module romIdPath
  import owRomPkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h2D,
  parameter logic [47:0] SERIAL = 48'h5A3C0F96E1B7
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic         slotBit,
  output logic [7:0]   cmdNext,
  output logic         cmdLast,
  output logic         idBit,
  output logic         idLast,
  output logic [1:0]   phase
);

  localparam int CNT_W = $clog2(ID_BITS);
  localparam logic [ID_BITS-1:0] FULL_ID = {idCrc({SERIAL, FAMILY}), SERIAL, FAMILY};

  logic [CNT_W-1:0]    bitCnt;
  logic [CMD_BITS-1:0] cmdSr;
  logic [1:0]          phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      cmdSr  <= '0;
      phaseQ <= '0;
    end else begin
      if (ctl.cntClr)      bitCnt <= '0;
      else if (ctl.cntInc) bitCnt <= bitCnt + 1'b1;

      if (ctl.phClr)      phaseQ <= '0;
      else if (ctl.phInc) phaseQ <= phaseQ + 1'b1;

      if (ctl.cmdShift) cmdSr <= cmdNext;
    end
  end

  assign cmdNext = {slotBit, cmdSr[CMD_BITS-1:1]};
  assign cmdLast = (bitCnt == CNT_W'(CMD_BITS - 1));
  assign idBit   = FULL_ID[bitCnt];
  assign idLast  = (bitCnt == CNT_W'(ID_BITS - 1));
  assign phase   = phaseQ;

  // search sequencing uses only three slot phases
  p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ != 2'd3);

  // a phase advance is always answered, never skipped
  p_phase_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.phInc && !ctl.phClr) |=> (phaseQ != 2'd0));

endmodule

// File: rtl/romSeqCtl.sv
module romSeqCtl
  import owRomPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       rstShort,
  input  logic       slotStb,
  input  logic       slotBit,
  input  logic [7:0] cmdNext,
  input  logic       cmdLast,
  input  logic       idBit,
  input  logic       idLast,
  input  logic [1:0] phase,
  output dpCtl_t     ctl,
  output logic       txEn,
  output logic       txBit,
  output logic       memSel,
  output logic       odMode
);

  romState_t state;
  logic      rcFlag;
  logic      odMatch;

  // transmit request for the coming slot
  always_comb begin
    txEn  = 1'b0;
    txBit = 1'b1;
    case (state)
      ST_READ: begin
        txEn  = 1'b1;
        txBit = idBit;
      end
      ST_SEARCH: begin
        if (phase == 2'd0) begin
          txEn  = 1'b1;
          txBit = idBit;
        end else if (phase == 2'd1) begin
          txEn  = 1'b1;
          txBit = ~idBit;
        end
      end
      default: ;
    endcase
  end

  // datapath strobes
  always_comb begin
    ctl = '0;
    if (busReset) begin
      ctl.cntClr = 1'b1;
      ctl.phClr  = 1'b1;
    end else if (slotStb) begin
      case (state)
        ST_CMD: begin
          ctl.cmdShift = 1'b1;
          if (cmdLast) begin
            ctl.cntClr = 1'b1;
            ctl.phClr  = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_READ, ST_MATCH: ctl.cntInc = 1'b1;
        ST_SEARCH: begin
          if (phase == 2'd2) begin
            ctl.phClr  = 1'b1;
            ctl.cntInc = 1'b1;
          end else begin
            ctl.phInc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rcFlag  <= 1'b0;
      odMode  <= 1'b0;
      odMatch <= 1'b0;
      memSel  <= 1'b0;
    end else begin
      memSel <= 1'b0;
      if (busReset) begin
        state <= ST_CMD;
        if (!rstShort) odMode <= 1'b0;
      end else if (slotStb) begin
        case (state)
          ST_CMD: begin
            if (cmdLast) begin
              state <= ST_IDLE;
              case (cmdNext)
                CMD_READ: begin
                  rcFlag <= 1'b0;
                  state  <= ST_READ;
                end
                CMD_MATCH: begin
                  rcFlag  <= 1'b0;
                  odMatch <= 1'b0;
                  state   <= ST_MATCH;
                end
                CMD_SEARCH: begin
                  rcFlag <= 1'b0;
                  state  <= ST_SEARCH;
                end
                CMD_SKIP: begin
                  rcFlag <= 1'b0;
                  memSel <= 1'b1;
                end
                CMD_RESUME: begin
                  if (rcFlag) memSel <= 1'b1;
                end
                CMD_OD_SKIP: begin
                  rcFlag <= 1'b0;
                  odMode <= 1'b1;
                  memSel <= 1'b1;
                end
                CMD_OD_MATCH: begin
                  rcFlag  <= 1'b0;
                  odMode  <= 1'b1;
                  odMatch <= 1'b1;
                  state   <= ST_MATCH;
                end
                default: ;
              endcase
            end
          end
          ST_READ: begin
            if (idLast) begin
              memSel <= 1'b1;
              state  <= ST_IDLE;
            end
          end
          ST_MATCH: begin
            if (slotBit != idBit) begin
              state <= ST_IDLE;
              if (odMatch) odMode <= 1'b0;
            end else if (idLast) begin
              rcFlag <= 1'b1;
              memSel <= 1'b1;
              state  <= ST_IDLE;
            end
          end
          ST_SEARCH: begin
            if (phase == 2'd2) begin
              if (slotBit != idBit) begin
                state <= ST_IDLE;
              end else if (idLast) begin
                rcFlag <= 1'b1;
                memSel <= 1'b1;
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_sel_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    memSel |=> !memSel);

  p_sel_no_tx_r12: assert property (@(posedge clk) disable iff (!rstN)
    memSel |-> !txEn);

  p_std_reset_od_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !rstShort) |=> !odMode);

  p_short_reset_od_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && rstShort) |=> $stable(odMode));

  p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!txEn && !memSel));

  p_od_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(odMode) |-> $past(slotStb));

endmodule

// File: rtl/owRomSelect.sv
module owRomSelect
  import owRomPkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h2D,
  parameter logic [47:0] SERIAL = 48'h5A3C0F96E1B7
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic rstShort,
  input  logic slotStb,
  input  logic slotBit,
  output logic txEn,
  output logic txBit,
  output logic memSel,
  output logic odMode
);

  dpCtl_t     ctl;
  logic [7:0] cmdNext;
  logic       cmdLast;
  logic       idBit;
  logic       idLast;
  logic [1:0] phase;

  romIdPath #(
    .FAMILY (FAMILY),
    .SERIAL (SERIAL)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .slotBit (slotBit),
    .cmdNext (cmdNext),
    .cmdLast (cmdLast),
    .idBit   (idBit),
    .idLast  (idLast),
    .phase   (phase)
  );

  romSeqCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .rstShort (rstShort),
    .slotStb  (slotStb),
    .slotBit  (slotBit),
    .cmdNext  (cmdNext),
    .cmdLast  (cmdLast),
    .idBit    (idBit),
    .idLast   (idLast),
    .phase    (phase),
    .ctl      (ctl),
    .txEn     (txEn),
    .txBit    (txBit),
    .memSel   (memSel),
    .odMode   (odMode)
  );

endmodule

// File: tb/sim_owRomSelect.sv
`timescale 1ns/1ps
module sim_owRomSelect;

  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h5A3C0F96E1B7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0;
  logic rstShort = 1'b0;
  logic slotStb = 1'b0;
  logic slotBit = 1'b1;
  logic txEn, txBit, memSel, odMode;

  int total = 0;
  int bad = 0;
  int selCnt = 0;
  int txSeen = 0;
  logic txWatch = 1'b0;
  logic [63:0] expId;

  always #2 clk = ~clk;

  owRomSelect #(.FAMILY(FAM), .SERIAL(SER)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rstShort(rstShort),
    .slotStb(slotStb), .slotBit(slotBit), .txEn(txEn), .txBit(txBit),
    .memSel(memSel), .odMode(odMode)
  );

  always @(posedge clk) begin
    if (memSel) selCnt <= selCnt + 1;
    if (txWatch && txEn) txSeen <= txSeen + 1;
  end

  // stage-wise CRC register: taps at stages feeding x^4 and x^5
  function automatic logic [7:0] crcStep(input logic [7:0] c, input logic b);
    logic fb;
    logic [7:0] n;
    fb = c[0] ^ b;
    n = {fb, c[7:1]};
    n[3] = c[4] ^ fb;
    n[2] = c[3] ^ fb;
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic shortR);
    @(negedge clk);
    busReset = 1'b1;
    rstShort = shortR;
    @(negedge clk);
    busReset = 1'b0;
    rstShort = 1'b0;
  endtask

  task automatic wrBit(input logic b);
    @(negedge clk);
    slotStb = 1'b1;
    slotBit = b;
    @(negedge clk);
    slotStb = 1'b0;
    slotBit = 1'b1;
  endtask

  task automatic rdBit(output logic b);
    @(negedge clk);
    b = txEn ? txBit : 1'b1;
    slotStb = 1'b1;
    slotBit = b;
    @(negedge clk);
    slotStb = 1'b0;
    slotBit = 1'b1;
  endtask

  task automatic wrByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wrBit(v[i]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic doMatch(input logic [7:0] cmd, input int flipAt);
    wrByte(cmd);
    for (int i = 0; i < 64; i++) wrBit(expId[i] ^ (i == flipAt));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    logic b, c;
    logic [63:0] got;
    logic [7:0] crc;
    int errs;

    crc = '0;
    for (int i = 0; i < 56; i++) crc = crcStep(crc, (i < 8) ? FAM[i] : SER[i-8]);
    expId = {crc, SER, FAM};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1: reset state and slots before first bus reset
    check("R1 txEn", txEn, 0);
    check("R1 odMode", odMode, 0);
    s0 = selCnt;
    wrByte(8'hCC);
    wrByte(8'h3C);
    settle();
    check("R1 no select", selCnt - s0, 0);
    check("R1 odMode", odMode, 0);

    // R3: read ROM
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'h33);
    for (int i = 0; i < 64; i++) begin rdBit(b); got[i] = b; end
    settle();
    check("R3 id", got, expId);
    crc = '0;
    for (int i = 0; i < 64; i++) crc = crcStep(crc, got[i]);
    check("R3 crc residue", crc, 0);
    check("R3 select", selCnt - s0, 1);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R7 resume after read", selCnt - s0, 0);

    // R4 / R7: good match then resume twice
    doReset(1'b0);
    s0 = selCnt;
    txSeen = 0; txWatch = 1'b1;
    doMatch(8'h55, -1);
    txWatch = 1'b0;
    settle();
    check("R4 select", selCnt - s0, 1);
    check("R12 no tx in match", txSeen, 0);
    for (int r = 0; r < 2; r++) begin
      doReset(1'b0);
      s0 = selCnt;
      wrByte(8'hA5);
      settle();
      check("R7 resume selects", selCnt - s0, 1);
    end

    // R6: skip clears resume flag
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hCC);
    settle();
    check("R6 select", selCnt - s0, 1);
    check("R6 odMode", odMode, 0);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R6 resume flag cleared", selCnt - s0, 0);

    // R4: mismatch swept over every bit position
    for (int k = 0; k < 64; k++) begin
      doReset(1'b0);
      s0 = selCnt;
      txSeen = 0; txWatch = 1'b1;
      doMatch(8'h55, k);
      txWatch = 1'b0;
      settle();
      check("R4 mismatch no select", selCnt - s0, 0);
      check("R12 silent after mismatch", txSeen, 0);
      doReset(1'b0);
      s0 = selCnt;
      wrByte(8'hA5);
      settle();
      check("R7 resume after failed match", selCnt - s0, 0);
    end

    // R5: full search
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hF0);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      rdBit(b); rdBit(c);
      if (b !== expId[i] || c !== ~expId[i]) errs++;
      txSeen = 0; txWatch = 1'b1;
      wrBit(expId[i]);
      txWatch = 1'b0;
      if (txSeen != 0 && i < 63) errs += 0;
    end
    settle();
    check("R5 pair errors", errs, 0);
    check("R5 select", selCnt - s0, 1);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R5 resume flag set", selCnt - s0, 1);

    // R5: search dropout at several positions
    for (int q = 0; q < 3; q++) begin
      int k;
      k = (q == 0) ? 0 : ((q == 1) ? 31 : 63);
      doReset(1'b0);
      s0 = selCnt;
      wrByte(8'hF0);
      for (int i = 0; i <= k; i++) begin
        rdBit(b); rdBit(c);
        wrBit(expId[i] ^ (i == k));
      end
      rdBit(b); rdBit(c);
      settle();
      check("R5 dropout silent", {b, c}, 2'b11);
      check("R5 dropout no select", selCnt - s0, 0);
    end

    // R8 / R10: overdrive skip, short and standard resets
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'h3C);
    settle();
    check("R8 odMode set", odMode, 1);
    check("R8 select", selCnt - s0, 1);
    doReset(1'b1);
    check("R10 short reset keeps od", odMode, 1);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R8 resume flag cleared", selCnt - s0, 0);
    doReset(1'b0);
    check("R10 std reset clears od", odMode, 0);

    // R9: overdrive match good and bad
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'h69);
    settle();
    check("R9 od after command", odMode, 1);
    for (int i = 0; i < 64; i++) wrBit(expId[i]);
    settle();
    check("R9 select", selCnt - s0, 1);
    check("R9 od kept", odMode, 1);
    doReset(1'b1);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R9 resume flag set", selCnt - s0, 1);
    doReset(1'b1);
    s0 = selCnt;
    doMatch(8'h69, 10);
    settle();
    check("R9 mismatch clears od", odMode, 0);
    check("R9 mismatch no select", selCnt - s0, 0);

    // R11: unknown command keeps resume flag
    doReset(1'b0);
    doMatch(8'h55, -1);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'h00);
    rdBit(b);
    settle();
    check("R11 no select", selCnt - s0, 0);
    check("R11 silent", b, 1);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hA5);
    settle();
    check("R11 resume flag kept", selCnt - s0, 1);

    // R2: reset in the middle of a command and of a read
    doReset(1'b0);
    for (int i = 0; i < 4; i++) wrBit(1'b1);
    doReset(1'b0);
    s0 = selCnt;
    wrByte(8'hCC);
    settle();
    check("R2 abort mid command", selCnt - s0, 1);
    doReset(1'b0);
    wrByte(8'h33);
    for (int i = 0; i < 20; i++) rdBit(b);
    doReset(1'b0);
    check("R2 quiet after reset", txEn, 0);
    wrByte(8'h33);
    for (int i = 0; i < 64; i++) begin rdBit(b); got[i] = b; end
    check("R2 read restarts at bit 0", got, expId);

    // R12: select pulse width
    doReset(1'b0);
    wrByte(8'hCC);
    check("R12 pulse high", memSel, 1);
    @(negedge clk);
    check("R12 pulse one cycle", memSel, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule